// File: doc/BRIEF.md
# Prescaled Timer PWM Channel

This block generates one pulse-width-modulated output from a 10-bit up-counting timer. The timer advances once per prescaler tick, at the system clock divided by 2, 8, 32 or 64. When the timer holds the programmed period value and the next tick arrives, the timer returns to zero, the output goes high and a one-clock interrupt pulse is raised. The output drops when the timer reaches the working duty value.

The working duty value is a private copy of the duty input. It is refreshed only at that period boundary, so software may change the duty input at any time and the waveform only changes at the start of the next period. Software can read the timer at any time. It can also load a value into the timer or clear it, and either action restarts the prescaler. Clearing the enable input freezes the timer and the output and resets the prescaler. A second channel is simply a second instance.

There is no streamed data at this block's edge, so every pin is a plain level or pulse and there is no valid/ready handshake. Tick, wrap and duty events all fall on system clock edges.

Top module: `pwm_chan`

## Requirements
- R1: While reset is asserted and just after its release, the timer reads 0, the output is low and the interrupt is low.
- R2: With enable high, the timer advances by one every N system clocks, where N is 2, 8, 32 or 64 for select codes 00, 01, 10 and 11. After a clear, the first advance happens on the N-th clock edge that follows.
- R3: A tick that arrives while the timer equals the period value returns the timer to 0, so one output cycle lasts period+1 ticks.
- R4: From a period boundary on, the output is high while the timer is below the working duty value and low once the timer reaches it. A working duty of 0 keeps the output low for the whole cycle. A working duty above the period keeps it high for the whole cycle.
- R5: The working duty value is copied from the duty input only at the tick that returns the timer to 0. A duty change in the middle of a period does not alter that period.
- R6: The interrupt is high for exactly one clock, in the clock cycle in which the timer first reads 0 after a period boundary. It is never high at any other time.
- R7: While enable is low, the timer and the output hold their values and no interrupt occurs. The prescaler restarts, so the first advance after enable returns comes N clocks later.
- R8: A clear pulse sets the timer to 0 on the next edge and restarts the prescaler. It takes priority over a simultaneous load.
- R9: A load pulse without clear sets the timer to the load value on the next edge and restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Timer enable |
| psc_sel | input | 2 | Prescaler select: 00=/2, 01=/8, 10=/32, 11=/64 |
| period | input | 10 | Last timer value of a cycle |
| duty | input | 10 | Requested high time in ticks |
| tmr_clr | input | 1 | Clear timer to 0 (one-clock pulse) |
| tmr_wr | input | 1 | Load timer from tmr_wdata (one-clock pulse) |
| tmr_wdata | input | 10 | Timer load value |
| tmr_q | output | 10 | Current timer value |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | One-clock pulse at each period boundary |

## Verification
The bench sweeps every prescaler ratio against several small periods. For each pair it tries duty values of 0, 1, the period and the period plus one, and predicts timer, output and interrupt arithmetically from the clock count since a clear. These duty values are the ones that expose an off-by-one in the wrap comparison, which would give a cycle of period or period+2 ticks. They also expose a duty-zero glitch, which would show as a one-tick high pulse, and a wrongly timed interrupt. Separate sequences change the duty in the middle of a period, where a design without buffering would cut the current pulse short. They also gate the enable and load or clear the timer with the prescaler partway through a count, where a prescaler that is not restarted would give an early first tick.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PSC_CW = 6;

  typedef enum logic [1:0] {
    PSC_DIV2  = 2'b00,
    PSC_DIV8  = 2'b01,
    PSC_DIV32 = 2'b10,
    PSC_DIV64 = 2'b11
  } psc_sel_e;

  // last prescaler count before a tick (ratio minus one)
  function automatic logic [PSC_CW-1:0] psc_last(input psc_sel_e s);
    case (s)
      PSC_DIV2:  return PSC_CW'(1);
      PSC_DIV8:  return PSC_CW'(7);
      PSC_DIV32: return PSC_CW'(31);
      default:   return PSC_CW'(63);
    endcase
  endfunction
endpackage

// File: rtl/pwm_psc.sv
module pwm_psc
  import pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PSC_CW-1:0] cnt;
  logic [PSC_CW-1:0] lim;

  assign lim  = psc_last(psc_sel_e'(sel));
  // >= keeps the count bounded if the ratio shrinks mid-count
  assign tick = run && !restart && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!run || restart || tick) cnt <= '0;
    else                             cnt <= cnt + PSC_CW'(1);
  end
endmodule

// File: rtl/pwm_tmr.sv
module pwm_tmr #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] period,
  output logic [W-1:0] tmr,
  output logic         wrap,
  output logic [W-1:0] tmr_nxt
);
  localparam logic [W-1:0] ONE = W'(1);

  assign wrap    = tick && (tmr == period);
  assign tmr_nxt = wrap ? '0 : tmr + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tmr <= '0;
    else if (clr)  tmr <= '0;
    else if (wr)   tmr <= wdata;
    else if (tick) tmr <= tmr_nxt;
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wrap,
  input  logic [W-1:0] tmr_nxt,
  input  logic [W-1:0] duty,
  output logic         pwm,
  output logic         irq
);
  logic [W-1:0] duty_l;
  logic [W-1:0] duty_use;
  logic         pwm_n;

  // the copy about to be in force for the tick being taken
  assign duty_use = wrap ? duty : duty_l;
  assign pwm_n    = (tmr_nxt == duty_use) ? 1'b0 : (wrap ? 1'b1 : pwm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_l <= '0;
      pwm    <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= wrap;
      if (tick) pwm <= pwm_n;
      if (wrap) duty_l <= duty;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   psc_sel,
  input  logic [W-1:0] period,
  input  logic [W-1:0] duty,
  input  logic         tmr_clr,
  input  logic         tmr_wr,
  input  logic [W-1:0] tmr_wdata,
  output logic [W-1:0] tmr_q,
  output logic         pwm_out,
  output logic         irq
);
  logic         tick;
  logic         wrap;
  logic [W-1:0] tmr_nxt;

  pwm_psc u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .restart (tmr_clr | tmr_wr),
    .sel     (psc_sel),
    .tick    (tick)
  );

  pwm_tmr #(.W(W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .clr     (tmr_clr),
    .wr      (tmr_wr),
    .wdata   (tmr_wdata),
    .period  (period),
    .tmr     (tmr_q),
    .wrap    (wrap),
    .tmr_nxt (tmr_nxt)
  );

  pwm_out_stage #(.W(W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wrap    (wrap),
    .tmr_nxt (tmr_nxt),
    .duty    (duty),
    .pwm     (pwm_out),
    .irq     (irq)
  );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         tmr_clr,
  input logic         tmr_wr,
  input logic [W-1:0] tmr_wdata,
  input logic [W-1:0] tmr_q,
  input logic         pwm_out,
  input logic         irq
);
  localparam logic [W-1:0] ONE = W'(1);

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq) else $error("R6 irq longer than one clock");

  p_irq_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tmr_q == '0)) else $error("R6 irq with nonzero timer");

  p_hold_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !tmr_wr && !tmr_clr) |=> ($stable(tmr_q) && $stable(pwm_out)))
    else $error("R7 state moved while disabled");

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |=> (tmr_q == '0)) else $error("R8 clear ignored");

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_wr && !tmr_clr) |=> (tmr_q == $past(tmr_wdata)))
    else $error("R9 load ignored");

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_wr && !tmr_clr) |=>
      (tmr_q == $past(tmr_q) || tmr_q == $past(tmr_q) + ONE || tmr_q == '0))
    else $error("R2 timer jumped");

  p_rise_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> (tmr_q == '0)) else $error("R4 rise away from boundary");
endmodule

bind pwm_chan pwm_chan_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .tmr_clr   (tmr_clr),
  .tmr_wr    (tmr_wr),
  .tmr_wdata (tmr_wdata),
  .tmr_q     (tmr_q),
  .pwm_out   (pwm_out),
  .irq       (irq)
);

// File: tb/test_pwm_chan.sv
module test_pwm_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] psc_sel = 2'b00;
  logic [9:0] period = '0;
  logic [9:0] duty = '0;
  logic       tmr_clr = 1'b0;
  logic       tmr_wr = 1'b0;
  logic [9:0] tmr_wdata = '0;
  logic [9:0] tmr_q;
  logic       pwm_out;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_chan i_pwm_chan (
    .clk(clk), .rst_n(rst_n), .en(en), .psc_sel(psc_sel),
    .period(period), .duty(duty), .tmr_clr(tmr_clr), .tmr_wr(tmr_wr),
    .tmr_wdata(tmr_wdata), .tmr_q(tmr_q), .pwm_out(pwm_out), .irq(irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // pulse clear: edge 0 of the count that follows
  task automatic do_clear();
    tmr_clr = 1'b1;
    step(1);
    tmr_clr = 1'b0;
  endtask

  task automatic sweep_one(input int sel, input int p, input int d);
    int dv;
    int tot;
    dv = (sel == 0) ? 2 : (sel == 1) ? 8 : (sel == 2) ? 32 : 64;
    psc_sel = 2'(sel);
    period  = 10'(p);
    duty    = 10'(d);
    do_clear();
    tot = 3 * (p + 1) * dv;
    for (int e = 1; e <= tot; e++) begin
      int n;
      int t;
      int ie;
      step(1);
      n  = e / dv;
      t  = n % (p + 1);
      ie = ((e % dv) == 0 && t == 0 && n > 0) ? 1 : 0;
      check("R2/R3", "timer", int'(tmr_q), t);
      check("R6", "irq", int'(irq), ie);
      if (n >= p + 1)
        check("R4", "pwm", int'(pwm_out), (t < d) ? 1 : 0);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(3);
    check("R1", "timer in reset", int'(tmr_q), 0);
    check("R1", "pwm in reset", int'(pwm_out), 0);
    check("R1", "irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    step(2);
    check("R1", "timer after release", int'(tmr_q), 0);
    check("R1", "pwm after release", int'(pwm_out), 0);
    en = 1'b1;

    // R2 R3 R4 R6 sweep over ratios, periods and duty corners
    for (int s = 0; s < 4; s++) begin
      for (int pi = 0; pi < 3; pi++) begin
        int p;
        p = (pi == 0) ? 0 : (pi == 1) ? 2 : 5;
        for (int di = 0; di < 4; di++) begin
          int d;
          d = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? p : p + 1;
          sweep_one(s, p, d);
        end
      end
    end

    // R5: duty change mid-period waits for the boundary (ratio 2, period 7)
    psc_sel = 2'b00; period = 10'd7; duty = 10'd2;
    do_clear();
    step(18);                       // n=9, timer 1, second cycle
    duty = 10'd5;
    step(4);                        // edge 22: n=11, timer 3
    check("R5", "timer", int'(tmr_q), 3);
    check("R5", "pwm old duty", int'(pwm_out), 0);
    step(16);                       // edge 38: n=19, timer 3
    check("R5", "timer", int'(tmr_q), 3);
    check("R5", "pwm new duty", int'(pwm_out), 1);
    step(4);                        // edge 42: n=21, timer 5
    check("R5", "pwm new duty end", int'(pwm_out), 0);

    // R7: enable gating with prescaler mid-count (ratio 8)
    psc_sel = 2'b01; period = 10'd7; duty = 10'd3;
    do_clear();
    step(10);                       // one tick taken, count at 2
    check("R7", "timer before gate", int'(tmr_q), 1);
    en = 1'b0;
    begin
      logic pw;
      int seen;
      pw = pwm_out;
      seen = 0;
      for (int i = 0; i < 60; i++) begin
        step(1);
        if (irq) seen++;
      end
      check("R7", "timer held", int'(tmr_q), 1);
      check("R7", "pwm held", int'(pwm_out), int'(pw));
      check("R7", "no irq while off", seen, 0);
    end
    en = 1'b1;
    step(7);
    check("R7", "no early tick", int'(tmr_q), 1);
    step(1);
    check("R7", "tick after restart", int'(tmr_q), 2);

    // R9: load restarts prescaler
    period = 10'd200;
    do_clear();
    step(3);
    tmr_wdata = 10'd150; tmr_wr = 1'b1;
    step(1);
    tmr_wr = 1'b0;
    check("R9", "load value", int'(tmr_q), 150);
    step(7);
    check("R9", "no early tick", int'(tmr_q), 150);
    step(1);
    check("R9", "tick after load", int'(tmr_q), 151);

    // R8: clear beats load, restarts prescaler
    step(3);
    tmr_wdata = 10'd77; tmr_wr = 1'b1; tmr_clr = 1'b1;
    step(1);
    tmr_wr = 1'b0; tmr_clr = 1'b0;
    check("R8", "clear priority", int'(tmr_q), 0);
    step(7);
    check("R8", "no early tick", int'(tmr_q), 0);
    step(1);
    check("R8", "tick after clear", int'(tmr_q), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule